// File: doc/BRIEF.md
# DMA Controller Register Interface

This block is the processor-facing programming port of a four-channel DMA controller. A processor reaches it over an 8-bit data bus with a 4-bit register offset and separate read and write enables. The processor uses it to program each channel's 16-bit start address and transfer count. It also sets per-channel masks, modes and software requests, issues a command word, and reads back status. The channel engines sit behind this block. They receive the loaded base values with a one-cycle load pulse, the mask and mode bits, and the command byte. They return terminal-count pulses, hardware requests, updated current address and count values, and a temporary data byte.

A 16-bit channel register is reached through an 8-bit port as two consecutive byte accesses. A single byte-pointer flag, shared by all four channels, picks the byte for each access. The flag flips on every read or write of a channel register, and software returns it to the low byte with a dedicated clear command. The remaining offsets pack a channel number and an action into one byte, so one write changes one channel.

Top module: `dmac_regif`

## Requirements
- R1: Offset 2·c (c = 0..3) is channel c's address register and offset 2·c+1 its count register. A write loads the byte chosen by the byte pointer into both the base copy (visible on `base_addr_o`/`base_cnt_o`, channel c at bits [16c+15:16c]) and the current copy.
- R2: The byte pointer is 0 (low byte) after reset. Every read or write at offsets 0x0–0x7 flips it, with 1 selecting bits [15:8]. Any write to offset 0xC returns it to 0.
- R3: A read at offsets 0x0–0x7 returns the pointer-selected byte of the current copy. A pulse on `eng_wr[c]` replaces channel c's current address and count with `eng_addr`/`eng_cnt` and leaves the base copy unchanged. The pulse is ignored in a cycle where the processor writes a channel-c register.
- R4: `ch_load[c]` is high for exactly the one cycle after the clock edge that writes a high byte of channel c, and never for more than one channel at a time.
- R5: A write to offset 0xA sets channel wdata[1:0]'s mask bit to wdata[2] (1 = masked).
- R6: A write to offset 0xE clears all four mask bits. A write to offset 0xF loads them from wdata[3:0].
- R7: A write to offset 0xB stores wdata[7:2] as the mode of channel wdata[1:0]. Channel c's mode appears on `ch_mode[6c+5:6c]`, with [5:4] = transfer mode, [2] = auto-initialise and [1:0] = direction.
- R8: A write to offset 0x8 stores wdata on `cmd_o`.
- R9: A write to offset 0x9 sets channel wdata[1:0]'s software request bit (`sw_req`) to wdata[2].
- R10: A read at offset 0x8 returns {sw_req | dreq_in, tc_flags}. A `tc_in[c]` pulse sets flag c and the flag stays set until a status read. The status read clears all flags except one pulsed in the same cycle.
- R11: A read at offset 0xD returns `temp_in`. A write to offset 0xD is a master clear. It sets all masks, zeroes the byte pointer, command, requests and terminal-count flags, and keeps modes and channel registers.
- R12: Reset leaves masks all set and everything else at zero. Reads at offsets 0x9–0xC, 0xE and 0xF return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of `rd_en` |
| tc_in | input | 4 | Per-channel terminal-count pulses |
| dreq_in | input | 4 | Per-channel hardware request levels |
| temp_in | input | 8 | Temporary data byte from the engines |
| eng_wr | input | 4 | Per-channel current-copy update strobe |
| eng_addr | input | 16 | Updated current address |
| eng_cnt | input | 16 | Updated current count |
| base_addr_o | output | 64 | Base addresses, 16 bits per channel |
| base_cnt_o | output | 64 | Base counts, 16 bits per channel |
| ch_load | output | 4 | One-cycle pulse after a high-byte load |
| ch_mask | output | 4 | Channel mask bits |
| ch_mode | output | 24 | Channel modes, 6 bits per channel |
| cmd_o | output | 8 | Command byte |
| sw_req | output | 4 | Software request bits |

## Verification
The assertions check the byte pointer on every cycle: it flips on each channel access and is zero after a clear or master clear. They also check the mask and flag effects of the clear commands, stickiness of the terminal-count flags, the timing and exclusivity of the load pulse, base-byte capture, and zero data on write-only offsets. Only the bench scenarios can show end-to-end byte ordering. These include interleaving of accesses to different channels through the one shared pointer, the effect of an engine update on read-back while the base copy holds, and master clear preserving modes and channel registers.

// File: rtl/dmac_regif_pkg.sv
package dmac_regif_pkg;
  localparam int DW    = 8;
  localparam int WW    = 16;
  localparam int NCH   = 4;
  localparam int CHW   = $clog2(NCH);
  localparam int MODEW = DW - CHW;
  localparam int OFSW  = 4;

  // Replace one byte of a 16-bit word; hi selects the upper byte.
  function automatic logic [WW-1:0] put_byte(input logic [WW-1:0] w,
                                             input logic [DW-1:0] b,
                                             input logic hi);
    logic [WW-1:0] r;
    r = w;
    if (hi) r[WW-1:DW] = b;
    else    r[DW-1:0]  = b;
    return r;
  endfunction

  // Pick one byte of a 16-bit word.
  function automatic logic [DW-1:0] get_byte(input logic [WW-1:0] w,
                                             input logic hi);
    return hi ? w[WW-1:DW] : w[DW-1:0];
  endfunction

  // One-hot channel vector from a channel number.
  function automatic logic [NCH-1:0] ch_bit(input logic [CHW-1:0] c);
    return NCH'(1) << c;
  endfunction
endpackage

// File: rtl/dmac_regif_dec.sv
module dmac_regif_dec
  import dmac_regif_pkg::*;
(
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [OFSW-1:0] ofs,
  output logic            ch_acc,
  output logic            ch_wr,
  output logic [CHW-1:0]  ch_sel,
  output logic            is_cnt,
  output logic            wr_cmd,
  output logic            wr_req,
  output logic            wr_mask1,
  output logic            wr_mode,
  output logic            wr_clrff,
  output logic            wr_mclr,
  output logic            wr_clrmask,
  output logic            wr_allmask,
  output logic            rd_stat,
  output logic            rd_temp
);
  always_comb begin
    ch_acc     = 1'b0;
    ch_wr      = 1'b0;
    ch_sel     = ofs[CHW:1];
    is_cnt     = ofs[0];
    wr_cmd     = 1'b0;
    wr_req     = 1'b0;
    wr_mask1   = 1'b0;
    wr_mode    = 1'b0;
    wr_clrff   = 1'b0;
    wr_mclr    = 1'b0;
    wr_clrmask = 1'b0;
    wr_allmask = 1'b0;
    rd_stat    = 1'b0;
    rd_temp    = 1'b0;
    if (!ofs[OFSW-1]) begin
      ch_acc = wr_en | rd_en;
      ch_wr  = wr_en;
    end else begin
      unique case (ofs[OFSW-2:0])
        3'd0: begin wr_cmd = wr_en; rd_stat = rd_en; end
        3'd1: wr_req     = wr_en;
        3'd2: wr_mask1   = wr_en;
        3'd3: wr_mode    = wr_en;
        3'd4: wr_clrff   = wr_en;
        3'd5: begin wr_mclr = wr_en; rd_temp = rd_en; end
        3'd6: wr_clrmask = wr_en;
        default: wr_allmask = wr_en;
      endcase
    end
  end
endmodule

// File: rtl/dmac_regif_chan.sv
module dmac_regif_chan
  import dmac_regif_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ch_wr,
  input  logic [CHW-1:0] ch_sel,
  input  logic          is_cnt,
  input  logic          ptr_hi,
  input  logic [DW-1:0] wdata,
  input  logic          eng_wr,
  input  logic [WW-1:0] eng_addr,
  input  logic [WW-1:0] eng_cnt,
  output logic [WW-1:0] base_addr,
  output logic [WW-1:0] base_cnt,
  output logic [WW-1:0] cur_addr,
  output logic [WW-1:0] cur_cnt,
  output logic          load_pulse
);
  logic hit;
  assign hit = ch_wr && (ch_sel == CHW'(IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr  <= '0;
      base_cnt   <= '0;
      cur_addr   <= '0;
      cur_cnt    <= '0;
      load_pulse <= 1'b0;
    end else begin
      load_pulse <= hit && ptr_hi;
      if (hit) begin
        if (is_cnt) begin
          base_cnt <= put_byte(base_cnt, wdata, ptr_hi);
          cur_cnt  <= put_byte(cur_cnt,  wdata, ptr_hi);
        end else begin
          base_addr <= put_byte(base_addr, wdata, ptr_hi);
          cur_addr  <= put_byte(cur_addr,  wdata, ptr_hi);
        end
      end else if (eng_wr) begin
        cur_addr <= eng_addr;
        cur_cnt  <= eng_cnt;
      end
    end
  end

  AST_BASE_LO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ptr_hi && !is_cnt) |=> (base_addr[DW-1:0] == $past(wdata))); // R1
  AST_BASE_HI_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ptr_hi && is_cnt) |=> (base_cnt[WW-1:DW] == $past(wdata))); // R1
  AST_LOAD_AFTER_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ptr_hi) |=> load_pulse); // R4
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && !(hit && ptr_hi)) |=> !load_pulse); // R4
  AST_ENG_KEEPS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_wr && !hit) |=> ($stable(base_addr) && $stable(base_cnt))); // R3
endmodule

// File: rtl/dmac_regif_ctrl.sv
module dmac_regif_ctrl
  import dmac_regif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch_acc,
  input  logic             wr_cmd,
  input  logic             wr_req,
  input  logic             wr_mask1,
  input  logic             wr_mode,
  input  logic             wr_clrff,
  input  logic             wr_mclr,
  input  logic             wr_clrmask,
  input  logic             wr_allmask,
  input  logic             rd_stat,
  input  logic [DW-1:0]    wdata,
  input  logic [NCH-1:0]   tc_in,
  output logic             ptr_hi,
  output logic [NCH-1:0]   mask,
  output logic [NCH-1:0]   req,
  output logic [NCH-1:0]   tc_flag,
  output logic [DW-1:0]    cmd,
  output logic [NCH*MODEW-1:0] modes
);
  logic [CHW-1:0]   wch;
  logic [NCH-1:0]   wsel;
  logic [MODEW-1:0] mode_q [NCH];

  assign wch  = wdata[CHW-1:0];
  assign wsel = ch_bit(wch);

  // Shared byte pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ptr_hi <= 1'b0;
    else if (wr_mclr || wr_clrff) ptr_hi <= 1'b0;
    else if (ch_acc)              ptr_hi <= ~ptr_hi;
  end

  // Masks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mask <= '1;
    else if (wr_mclr)    mask <= '1;
    else if (wr_clrmask) mask <= '0;
    else if (wr_allmask) mask <= wdata[NCH-1:0];
    else if (wr_mask1)   mask <= wdata[CHW] ? (mask | wsel) : (mask & ~wsel);
  end

  // Software requests
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        req <= '0;
    else if (wr_mclr)  req <= '0;
    else if (wr_req)   req <= wdata[CHW] ? (req | wsel) : (req & ~wsel);
  end

  // Terminal-count flags: sticky until a status read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tc_flag <= '0;
    else if (wr_mclr) tc_flag <= '0;
    else              tc_flag <= (rd_stat ? '0 : tc_flag) | tc_in;
  end

  // Command byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmd <= '0;
    else if (wr_mclr) cmd <= '0;
    else if (wr_cmd)  cmd <= wdata;
  end

  // Per-channel modes, untouched by master clear
  for (genvar c = 0; c < NCH; c++) begin : g_mode
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mode_q[c] <= '0;
      else if (wr_mode && wch == CHW'(c)) mode_q[c] <= wdata[DW-1:CHW];
    end
    assign modes[c*MODEW +: MODEW] = mode_q[c];
  end

  AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_acc && !wr_clrff && !wr_mclr) |=> (ptr_hi != $past(ptr_hi))); // R2
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clrff || wr_mclr) |=> !ptr_hi); // R2
  AST_MASK_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clrmask && !wr_mclr) |=> (mask == '0)); // R6
  AST_MASK_ONE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask1 && !wr_mclr && !wr_clrmask && !wr_allmask)
      |=> (($past(mask) ^ mask) & ~$past(wsel)) == '0); // R5
  AST_MCLR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mclr |=> (mask == '1 && req == '0 && cmd == '0 && tc_flag == '0 && !ptr_hi)); // R11
  AST_TC_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && tc_in == '0) |=> (tc_flag == '0)); // R10
  AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stat && !wr_mclr) |=> ((tc_flag & $past(tc_flag)) == $past(tc_flag))); // R10
endmodule

// File: rtl/dmac_regif.sv
module dmac_regif
  import dmac_regif_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [OFSW-1:0]      addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  input  logic [NCH-1:0]       tc_in,
  input  logic [NCH-1:0]       dreq_in,
  input  logic [DW-1:0]        temp_in,
  input  logic [NCH-1:0]       eng_wr,
  input  logic [WW-1:0]        eng_addr,
  input  logic [WW-1:0]        eng_cnt,
  output logic [NCH*WW-1:0]    base_addr_o,
  output logic [NCH*WW-1:0]    base_cnt_o,
  output logic [NCH-1:0]       ch_load,
  output logic [NCH-1:0]       ch_mask,
  output logic [NCH*MODEW-1:0] ch_mode,
  output logic [DW-1:0]        cmd_o,
  output logic [NCH-1:0]       sw_req
);
  // Decoded events, brought out as named wires
  logic           ch_acc, ch_wr, is_cnt;
  logic [CHW-1:0] ch_sel;
  logic           wr_cmd, wr_req, wr_mask1, wr_mode, wr_clrff, wr_mclr;
  logic           wr_clrmask, wr_allmask, rd_stat, rd_temp;
  logic           ptr_hi;
  logic [NCH-1:0] tc_flag;
  logic [WW-1:0]  cur_a [NCH];
  logic [WW-1:0]  cur_c [NCH];
  logic           wo_read;

  dmac_regif_dec u_dec (
    .wr_en, .rd_en, .ofs(addr),
    .ch_acc, .ch_wr, .ch_sel, .is_cnt,
    .wr_cmd, .wr_req, .wr_mask1, .wr_mode, .wr_clrff, .wr_mclr,
    .wr_clrmask, .wr_allmask, .rd_stat, .rd_temp
  );

  dmac_regif_ctrl u_ctrl (
    .clk, .rst_n, .ch_acc,
    .wr_cmd, .wr_req, .wr_mask1, .wr_mode, .wr_clrff, .wr_mclr,
    .wr_clrmask, .wr_allmask, .rd_stat, .wdata, .tc_in,
    .ptr_hi, .mask(ch_mask), .req(sw_req), .tc_flag, .cmd(cmd_o),
    .modes(ch_mode)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dmac_regif_chan #(.IDX(c)) u_chan (
      .clk, .rst_n, .ch_wr, .ch_sel, .is_cnt, .ptr_hi, .wdata,
      .eng_wr(eng_wr[c]), .eng_addr, .eng_cnt,
      .base_addr(base_addr_o[c*WW +: WW]),
      .base_cnt(base_cnt_o[c*WW +: WW]),
      .cur_addr(cur_a[c]), .cur_cnt(cur_c[c]),
      .load_pulse(ch_load[c])
    );
  end

  // Read mux
  always_comb begin
    rdata = '0;
    if (rd_en && ch_acc)
      rdata = get_byte(is_cnt ? cur_c[ch_sel] : cur_a[ch_sel], ptr_hi);
    else if (rd_stat)
      rdata = {sw_req | dreq_in, tc_flag};
    else if (rd_temp)
      rdata = temp_in;
  end

  assign wo_read = rd_en && addr[OFSW-1] && !rd_stat && !rd_temp;

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wo_read |-> (rdata == '0)); // R12
  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_load)); // R4
  AST_STAT_REQ_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |-> (rdata[DW-1:NCH] == (sw_req | dreq_in))); // R10
endmodule

// File: tb/dmac_regif_tb.sv
`timescale 1ns/1ps
module dmac_regif_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  tc_in = '0, dreq_in = '0, eng_wr = '0;
  logic [7:0]  temp_in = 8'hA5;
  logic [15:0] eng_addr = '0, eng_cnt = '0;
  logic [63:0] base_addr_o, base_cnt_o;
  logic [3:0]  ch_load, ch_mask, sw_req;
  logic [23:0] ch_mode;
  logic [7:0]  cmd_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dmac_regif u_dut (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
    .tc_in, .dreq_in, .temp_in, .eng_wr, .eng_addr, .eng_cnt,
    .base_addr_o, .base_cnt_o, .ch_load, .ch_mask, .ch_mode, .cmd_o, .sw_req
  );

  // Vector: {wr, rd, offset, wdata, expected rdata}
  localparam int NV = 26;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1,1'b0,4'hC,8'h00,8'h00},  // clear pointer (R2)
    {1'b1,1'b0,4'h2,8'h34,8'h00},  // ch1 addr low (R1)
    {1'b1,1'b0,4'h2,8'h12,8'h00},  // ch1 addr high (R1)
    {1'b0,1'b1,4'h2,8'h00,8'h34},
    {1'b0,1'b1,4'h2,8'h00,8'h12},
    {1'b1,1'b0,4'h7,8'hCD,8'h00},  // ch3 count (R1)
    {1'b1,1'b0,4'h7,8'hAB,8'h00},
    {1'b0,1'b1,4'h7,8'h00,8'hCD},
    {1'b0,1'b1,4'h7,8'h00,8'hAB},
    {1'b1,1'b0,4'h0,8'h11,8'h00},  // ch0 low, pointer now high (R2 shared)
    {1'b0,1'b1,4'h6,8'h00,8'h00},  // ch3 addr high byte
    {1'b0,1'b1,4'h2,8'h00,8'h34},
    {1'b0,1'b1,4'h2,8'h00,8'h12},
    {1'b1,1'b0,4'h2,8'h55,8'h00},  // pointer -> high
    {1'b1,1'b0,4'hC,8'h00,8'h00},  // clear pointer (R2)
    {1'b0,1'b1,4'h2,8'h00,8'h55},
    {1'b0,1'b1,4'h2,8'h00,8'h12},
    {1'b1,1'b0,4'hE,8'h00,8'h00},  // clear masks (R6)
    {1'b0,1'b1,4'hF,8'h00,8'h00},  // write-only read (R12)
    {1'b0,1'b1,4'h8,8'h00,8'h00},  // status (R10)
    {1'b1,1'b0,4'h9,8'h06,8'h00},  // request ch2 set (R9)
    {1'b0,1'b1,4'h8,8'h00,8'h40},
    {1'b1,1'b0,4'h9,8'h02,8'h00},  // request ch2 clear (R9)
    {1'b0,1'b1,4'h8,8'h00,8'h00},
    {1'b0,1'b1,4'hD,8'h00,8'hA5},  // temp read (R11)
    {1'b0,1'b1,4'hB,8'h00,8'h00}   // write-only read (R12)
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    chk("R12 reset mask", ch_mask, 4'hF);
    chk("R12 reset cmd", cmd_o, 8'h00);
    chk("R12 reset req", sw_req, 4'h0);
    chk("R12 reset load", ch_load, 4'h0);
    rd(4'h8, d); chk("R12 reset status", d, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      if (v[20]) begin
        rd(v[19:16], d);
        if (v[19:16] < 4'h8)       chk($sformatf("R3 entry %0d", i), d, v[7:0]);
        else if (v[19:16] == 4'h8) chk($sformatf("R10 entry %0d", i), d, v[7:0]);
        else if (v[19:16] == 4'hD) chk($sformatf("R11 entry %0d", i), d, v[7:0]);
        else                       chk($sformatf("R12 entry %0d", i), d, v[7:0]);
      end else begin
        wr(v[19:16], v[15:8]);
      end
    end

    // R1: base copies
    chk("R1 base addr ch1", base_addr_o[31:16], 16'h1255);
    chk("R1 base cnt ch3", base_cnt_o[63:48], 16'hABCD);
    chk("R6 masks after clear", ch_mask, 4'h0);

    // R4: load pulse timing
    wr(4'h4, 8'h22); chk("R4 no load on low byte", ch_load, 4'h0);
    wr(4'h4, 8'h33); chk("R4 load pulse ch2", ch_load, 4'b0100);
    @(negedge clk);  chk("R4 load pulse ends", ch_load, 4'h0);
    chk("R1 base addr ch2", base_addr_o[47:32], 16'h3322);

    // R5 / R6: masks
    wr(4'hA, 8'h05); chk("R5 mask ch1 set", ch_mask, 4'b0010);
    wr(4'hA, 8'h01); chk("R5 mask ch1 clear", ch_mask, 4'b0000);
    wr(4'hF, 8'h09); chk("R6 write all masks", ch_mask, 4'b1001);

    // R7: mode
    wr(4'hB, 8'h56); chk("R7 mode ch2", ch_mode[17:12], 6'h15);
    chk("R7 mode ch0 untouched", ch_mode[5:0], 6'h00);

    // R8: command
    wr(4'h8, 8'h3C); chk("R8 command", cmd_o, 8'h3C);

    // R10: terminal count and hardware requests
    tc_in = 4'b0101; @(negedge clk); tc_in = 4'b0000;
    @(negedge clk);
    rd(4'h8, d); chk("R10 tc flags held", d, 8'h05);
    rd(4'h8, d); chk("R10 tc cleared by read", d, 8'h00);
    dreq_in = 4'b1000;
    rd(4'h8, d); chk("R10 dreq in status", d, 8'h80);
    dreq_in = 4'b0000;

    // R3: engine update of current copy
    eng_addr = 16'hBEEF; eng_cnt = 16'h0123; eng_wr = 4'b0010;
    @(negedge clk); eng_wr = 4'b0000;
    wr(4'hC, 8'h00);
    rd(4'h2, d); chk("R3 cur addr low", d, 8'hEF);
    rd(4'h2, d); chk("R3 cur addr high", d, 8'hBE);
    rd(4'h3, d); chk("R3 cur cnt low", d, 8'h23);
    rd(4'h3, d); chk("R3 cur cnt high", d, 8'h01);
    chk("R3 base unchanged", base_addr_o[31:16], 16'h1255);

    // R11: master clear
    wr(4'h9, 8'h04);
    tc_in = 4'b1000; @(negedge clk); tc_in = 4'b0000;
    rd(4'h0, d);     // pointer now high
    wr(4'hD, 8'h00);
    chk("R11 mclr mask", ch_mask, 4'hF);
    chk("R11 mclr cmd", cmd_o, 8'h00);
    chk("R11 mclr req", sw_req, 4'h0);
    chk("R11 mode kept", ch_mode[17:12], 6'h15);
    rd(4'h8, d); chk("R11 mclr status", d, 8'h00);
    rd(4'h0, d); chk("R11 mclr pointer low", d, 8'h11);
    chk("R11 base kept", base_cnt_o[63:48], 16'hABCD);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule